// File: doc/BRIEF.md
# Integer Line-Doubling Video Scaler

This block takes a progressive, low-resolution RGB stream (24-bit pixels with valid, line-start and frame-start markers) and produces a larger progressive raster. The output is enlarged by a whole-number factor N of 2, 3 or 4. Each input pixel is repeated N times across a line. Each input line is sent out N times. With a 320x240 source this gives 640x480, 960x720 or 1280x960.

Only two line memories are used, in ping-pong fashion. While one input line is being written, the line completed before it is replayed on the output pixel clock. The latency is therefore about one input line, far below a frame. A line-done toggle carries each completed line from the input clock domain to the output clock domain.

The output path applies a contrast gain and a brightness offset. As an option, it darkens the last replayed copy of every input line to imitate the gaps between scanlines on a tube display. The output clock must be fast enough to replay N copies of N*IN_W pixels, each followed by OUT_HBLANK blanking cycles, within one input line period.

Top module: `line_scaler`

## Requirements
- R1: Within an output line, every input pixel appears on N consecutive data-enable cycles, in input order. Each output line carries N*IN_W active pixels with out_de held high throughout.
- R2: Each completed input line is output as exactly N consecutive lines of identical content, in input line order. A line that is being written never disturbs the line being replayed.
- R3: The factor N is decoded from scale_code as follows: 0 gives 2, 1 gives 3, 2 and 3 both give 4. A frame of L input lines gives N*L output lines.
- R4: A new scale_code value is taken only when the first line of a frame starts replaying. A change made in the middle of a frame leaves the rest of that frame at the old factor.
- R5: out_vsync is high for exactly one cycle, together with the first active pixel of the first output line of each frame, and at no other time.
- R6: After each output line come OUT_HBLANK blank cycles. out_hsync is high for the first HS_LEN of them and is never high while out_de is high.
- R7: Each 8-bit channel c is graded as y = clamp(floor(c*contrast/128) + bright, 0, 255). Here contrast is unsigned with 0x80 meaning unity gain, and bright is a signed two's-complement value.
- R8: When scan_en is 1, the N-th (last) copy of every input line outputs each graded channel shifted right by one. The other copies, and all copies when scan_en is 0, are not darkened.
- R9: While out_rst_n is low, and afterwards until a line has been received, out_de, out_hsync and out_vsync are 0 and out_rgb is 0.
- R10: A cycle with in_hsync or in_vsync high resets the input column to 0, and any in_valid pixel on that cycle is dropped. in_vsync marks the next completed line as the first of a frame. Pixels from a line cut short by a marker never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input pixel clock |
| in_rst_n | input | 1 | Asynchronous active-low reset, input domain |
| in_valid | input | 1 | Input pixel qualifier |
| in_hsync | input | 1 | Line-start marker, one cycle |
| in_vsync | input | 1 | Frame-start marker, one cycle |
| in_rgb | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| out_clk | input | 1 | Output pixel clock |
| out_rst_n | input | 1 | Asynchronous active-low reset, output domain |
| scale_code | input | 2 | Scale factor select (see R3) |
| scan_en | input | 1 | Scanline darkening enable |
| contrast | input | 8 | Gain, 1.7 fixed point unsigned |
| bright | input | 8 | Signed offset added after the gain |
| out_de | output | 1 | Output data enable |
| out_hsync | output | 1 | Output line sync |
| out_vsync | output | 1 | Output frame-start pulse |
| out_rgb | output | 24 | Output pixel, 0 when out_de is low |

## Verification
Frames of position-coded pixels are replayed under every scale code. Each frame uses a different mix of contrast, brightness and scanline settings: unity gain shows pure replication, halved gain with an offset shows the arithmetic, and large gains and negative offsets drive the clamp at both ends. Because every pixel's value depends on its column, line and frame, a mix-up in repeat count, line order or ping-pong bank shows up as a wrong value rather than passing unnoticed. Directed frames change the scale code part way through a frame, and cut a line short with a marker followed by junk, to separate frame-boundary latching and column restart from the normal path.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int GAIN_W = 8;
    localparam int FRAC_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACT,
        ST_BLK
    } eng_st_e;

    function automatic logic [2:0] code_to_n(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [CH_W-1:0] grade(input logic [CH_W-1:0]   lvl,
                                              input logic [GAIN_W-1:0] gain,
                                              input logic [CH_W-1:0]   offs);
        logic [CH_W+GAIN_W-1:0]        prod;
        logic signed [CH_W+GAIN_W+1:0] sum;
        prod = lvl * gain;
        sum  = $signed({2'b00, prod >> FRAC_W})
             + $signed({{(GAIN_W+2){offs[CH_W-1]}}, offs});
        if (sum < 0)
            return '0;
        else if (sum > $signed({{(GAIN_W+2){1'b0}}, {CH_W{1'b1}}}))
            return {CH_W{1'b1}};
        else
            return sum[CH_W-1:0];
    endfunction

endpackage

// File: rtl/scl_in_writer.sv
module scl_in_writer #(
    parameter int IN_W = 320,
    parameter int AW   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          hsync,
    input  logic          vsync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          ln_tgl,
    output logic          ln_bank,
    output logic          ln_first
);
    localparam int XW = (IN_W > 1) ? $clog2(IN_W) : 1;

    typedef struct packed {
        logic [XW-1:0] x;
        logic          wbank;
        logic          frm;
        logic          tgl;
        logic          dbank;
        logic          dfirst;
    } wr_s;

    wr_s wr_d, wr_q;

    always_comb begin
        wr_d = wr_q;
        we   = 1'b0;
        if (vsync) begin
            wr_d.x   = '0;
            wr_d.frm = 1'b1;
        end else if (hsync) begin
            wr_d.x = '0;
        end else if (valid) begin
            we = 1'b1;
            if (wr_q.x == XW'(IN_W - 1)) begin
                wr_d.x      = '0;
                wr_d.tgl    = ~wr_q.tgl;
                wr_d.dbank  = wr_q.wbank;
                wr_d.wbank  = ~wr_q.wbank;
                wr_d.dfirst = wr_q.frm;
                wr_d.frm    = 1'b0;
            end else begin
                wr_d.x = wr_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign waddr    = wr_q.wbank ? (AW'(IN_W) + AW'(wr_q.x)) : AW'(wr_q.x);
    assign ln_tgl   = wr_q.tgl;
    assign ln_bank  = wr_q.dbank;
    assign ln_first = wr_q.dfirst;

endmodule

// File: rtl/scl_line_ram.sv
module scl_line_ram #(
    parameter int DEPTH = 640,
    parameter int DW    = 24,
    parameter int AW    = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/scl_out_engine.sv
module scl_out_engine
    import scl_pkg::*;
#(
    parameter int IN_W       = 320,
    parameter int OUT_HBLANK = 160,
    parameter int HS_LEN     = 96,
    parameter int AW         = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln_tgl,
    input  logic          ln_bank,
    input  logic          ln_first,
    input  logic [1:0]    scale_code,
    input  logic          scan_en,
    output logic [AW-1:0] raddr,
    output logic          de1,
    output logic          hs1,
    output logic          vs1,
    output logic          dim1,
    output logic [2:0]    cur_n,
    output logic          vs_start
);
    localparam int XW = (IN_W > 1) ? $clog2(IN_W) : 1;
    localparam int BW = $clog2(OUT_HBLANK + 1);

    typedef struct packed {
        eng_st_e       st;
        logic          s1;
        logic          s2;
        logic          s3;
        logic          pend;
        logic          bank;
        logic [2:0]    n;
        logic [XW-1:0] x;
        logic [1:0]    rep;
        logic [1:0]    copy;
        logic [BW-1:0] blk;
        logic          vs;
        logic          de1;
        logic          hs1;
        logic          vs1;
        logic          dim1;
    } eng_s;

    eng_s eng_d, eng_q;
    logic de0, hs0, dim0, last_rep, last_copy;

    assign last_rep  = ({1'b0, eng_q.rep}  == eng_q.n - 3'd1);
    assign last_copy = ({1'b0, eng_q.copy} == eng_q.n - 3'd1);
    assign de0       = (eng_q.st == ST_ACT);
    assign hs0       = (eng_q.st == ST_BLK) && (eng_q.blk < BW'(HS_LEN));
    assign dim0      = de0 && scan_en && last_copy;

    always_comb begin
        eng_d      = eng_q;
        eng_d.s1   = ln_tgl;
        eng_d.s2   = eng_q.s1;
        eng_d.s3   = eng_q.s2;
        eng_d.vs   = 1'b0;
        eng_d.de1  = de0;
        eng_d.hs1  = hs0;
        eng_d.vs1  = eng_q.vs;
        eng_d.dim1 = dim0;
        case (eng_q.st)
            ST_IDLE: begin
                if (eng_q.pend) begin
                    eng_d.pend = 1'b0;
                    eng_d.bank = ln_bank;
                    if (ln_first) begin
                        eng_d.n  = code_to_n(scale_code);
                        eng_d.vs = 1'b1;
                    end
                    eng_d.x    = '0;
                    eng_d.rep  = '0;
                    eng_d.copy = '0;
                    eng_d.st   = ST_ACT;
                end
            end
            ST_ACT: begin
                if (last_rep) begin
                    eng_d.rep = '0;
                    if (eng_q.x == XW'(IN_W - 1)) begin
                        eng_d.x   = '0;
                        eng_d.blk = '0;
                        eng_d.st  = ST_BLK;
                    end else begin
                        eng_d.x = eng_q.x + 1'b1;
                    end
                end else begin
                    eng_d.rep = eng_q.rep + 1'b1;
                end
            end
            ST_BLK: begin
                if (eng_q.blk == BW'(OUT_HBLANK - 1)) begin
                    if (last_copy) begin
                        eng_d.st = ST_IDLE;
                    end else begin
                        eng_d.copy = eng_q.copy + 1'b1;
                        eng_d.st   = ST_ACT;
                    end
                end else begin
                    eng_d.blk = eng_q.blk + 1'b1;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        if (eng_q.s2 ^ eng_q.s3) eng_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
            eng_q.n  <= 3'd2;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign raddr    = eng_q.bank ? (AW'(IN_W) + AW'(eng_q.x)) : AW'(eng_q.x);
    assign de1      = eng_q.de1;
    assign hs1      = eng_q.hs1;
    assign vs1      = eng_q.vs1;
    assign dim1     = eng_q.dim1;
    assign cur_n    = eng_q.n;
    assign vs_start = eng_q.vs;

endmodule

// File: rtl/scl_pix_fx.sv
module scl_pix_fx
    import scl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  rdata,
    input  logic              de1,
    input  logic              hs1,
    input  logic              vs1,
    input  logic              dim1,
    input  logic [GAIN_W-1:0] contrast,
    input  logic [CH_W-1:0]   bright,
    output logic              out_de,
    output logic              out_hsync,
    output logic              out_vsync,
    output logic [PIX_W-1:0]  out_rgb
);
    typedef struct packed {
        logic             de;
        logic             hs;
        logic             vs;
        logic [PIX_W-1:0] rgb;
    } fx_s;

    fx_s fx_d, fx_q;
    logic [PIX_W-1:0] shaded;

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        logic [CH_W-1:0] lvl;
        assign lvl = grade(rdata[ch*CH_W +: CH_W], contrast, bright);
        assign shaded[ch*CH_W +: CH_W] = dim1 ? (lvl >> 1) : lvl;
    end

    always_comb begin
        fx_d     = fx_q;
        fx_d.de  = de1;
        fx_d.hs  = hs1;
        fx_d.vs  = vs1;
        fx_d.rgb = de1 ? shaded : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fx_q <= '0;
        else        fx_q <= fx_d;
    end

    assign out_de    = fx_q.de;
    assign out_hsync = fx_q.hs;
    assign out_vsync = fx_q.vs;
    assign out_rgb   = fx_q.rgb;

endmodule

// File: rtl/line_scaler.sv
module line_scaler
    import scl_pkg::*;
#(
    parameter int IN_W       = 320,
    parameter int OUT_HBLANK = 160,
    parameter int HS_LEN     = 96
) (
    input  logic        in_clk,
    input  logic        in_rst_n,
    input  logic        in_valid,
    input  logic        in_hsync,
    input  logic        in_vsync,
    input  logic [23:0] in_rgb,
    input  logic        out_clk,
    input  logic        out_rst_n,
    input  logic [1:0]  scale_code,
    input  logic        scan_en,
    input  logic [7:0]  contrast,
    input  logic [7:0]  bright,
    output logic        out_de,
    output logic        out_hsync,
    output logic        out_vsync,
    output logic [23:0] out_rgb
);
    localparam int DEPTH = 2 * IN_W;
    localparam int AW    = $clog2(DEPTH);

    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic             ln_tgl, ln_bank, ln_first;
    logic [PIX_W-1:0] rdata;
    logic             de1, hs1, vs1, dim1;
    logic [2:0]       cur_n;
    logic             vs_start;

    scl_in_writer #(.IN_W(IN_W), .AW(AW)) i_wr (
        .clk(in_clk), .rst_n(in_rst_n), .valid(in_valid),
        .hsync(in_hsync), .vsync(in_vsync), .we(we), .waddr(waddr),
        .ln_tgl(ln_tgl), .ln_bank(ln_bank), .ln_first(ln_first)
    );

    scl_line_ram #(.DEPTH(DEPTH), .DW(PIX_W), .AW(AW)) i_ram (
        .wclk(in_clk), .we(we), .waddr(waddr), .wdata(in_rgb),
        .rclk(out_clk), .raddr(raddr), .rdata(rdata)
    );

    scl_out_engine #(.IN_W(IN_W), .OUT_HBLANK(OUT_HBLANK),
                     .HS_LEN(HS_LEN), .AW(AW)) i_eng (
        .clk(out_clk), .rst_n(out_rst_n), .ln_tgl(ln_tgl),
        .ln_bank(ln_bank), .ln_first(ln_first), .scale_code(scale_code),
        .scan_en(scan_en), .raddr(raddr), .de1(de1), .hs1(hs1),
        .vs1(vs1), .dim1(dim1), .cur_n(cur_n), .vs_start(vs_start)
    );

    scl_pix_fx i_fx (
        .clk(out_clk), .rst_n(out_rst_n), .rdata(rdata), .de1(de1),
        .hs1(hs1), .vs1(vs1), .dim1(dim1), .contrast(contrast),
        .bright(bright), .out_de(out_de), .out_hsync(out_hsync),
        .out_vsync(out_vsync), .out_rgb(out_rgb)
    );

endmodule

// File: rtl/line_scaler_chk.sv
module line_scaler_chk #(
    parameter int IN_W   = 320,
    parameter int HS_LEN = 96
) (
    input logic       out_clk,
    input logic       out_rst_n,
    input logic       out_de,
    input logic       out_hsync,
    input logic       out_vsync,
    input logic [2:0] eng_n,
    input logic       eng_vs
);
    localparam int RW = $clog2(4 * IN_W + 2);
    localparam int HW = $clog2(HS_LEN + 2);

    logic [RW-1:0] run_q;
    logic [HW-1:0] hs_run_q;

    always_ff @(posedge out_clk or negedge out_rst_n) begin
        if (!out_rst_n) begin
            run_q    <= '0;
            hs_run_q <= '0;
        end else begin
            run_q    <= out_de    ? run_q + 1'b1    : '0;
            hs_run_q <= out_hsync ? hs_run_q + 1'b1 : '0;
        end
    end

    // R6
    hs_de_excl_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        !(out_de && out_hsync));

    // R6
    hs_len_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        $fell(out_hsync) |-> (32'(hs_run_q) == HS_LEN));

    // R5
    vs_on_de_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        out_vsync |-> out_de);

    // R4
    scale_hold_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        (eng_n != $past(eng_n)) |-> eng_vs);

    // R1
    line_len_chk: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        $fell(out_de) |-> (32'(run_q) == 32'(eng_n) * IN_W));

endmodule

bind line_scaler line_scaler_chk #(.IN_W(IN_W), .HS_LEN(HS_LEN)) i_chk (
    .out_clk(out_clk), .out_rst_n(out_rst_n), .out_de(out_de),
    .out_hsync(out_hsync), .out_vsync(out_vsync),
    .eng_n(cur_n), .eng_vs(vs_start)
);

// File: tb/test_line_scaler.sv
module test_line_scaler;

    localparam int CLK_PERIOD = 10;
    localparam int IN_PERIOD  = 30;
    localparam int W          = 8;
    localparam int HB         = 6;
    localparam int HSL        = 2;
    localparam int LINES      = 4;
    localparam int GAP        = 60;
    localparam int NVEC       = 6;

    // {expected N[21:19], scale_code[18:17], scan[16], contrast[15:8], bright[7:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {3'd2, 2'd0, 1'b0, 8'h80, 8'h00},
        {3'd3, 2'd1, 1'b1, 8'h80, 8'h00},
        {3'd4, 2'd2, 1'b0, 8'h40, 8'h10},
        {3'd4, 2'd3, 1'b1, 8'hFF, 8'h64},
        {3'd2, 2'd0, 1'b0, 8'h80, 8'h80},
        {3'd3, 2'd1, 1'b1, 8'hC0, 8'hEC}
    };

    logic        in_clk = 0, out_clk = 0;
    logic        in_rst_n = 0, out_rst_n = 0;
    logic        in_valid = 0, in_hsync = 0, in_vsync = 0;
    logic [23:0] in_rgb = '0;
    logic [1:0]  scale_code = '0;
    logic        scan_en = 0;
    logic [7:0]  contrast = 8'h80, bright = 8'h00;
    logic        out_de, out_hsync, out_vsync;
    logic [23:0] out_rgb;

    line_scaler #(.IN_W(W), .OUT_HBLANK(HB), .HS_LEN(HSL)) i_line_scaler (
        .in_clk(in_clk), .in_rst_n(in_rst_n), .in_valid(in_valid),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .in_rgb(in_rgb),
        .out_clk(out_clk), .out_rst_n(out_rst_n), .scale_code(scale_code),
        .scan_en(scan_en), .contrast(contrast), .bright(bright),
        .out_de(out_de), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_rgb(out_rgb)
    );

    always #(CLK_PERIOD/2) out_clk = ~out_clk;
    always #(IN_PERIOD/2)  in_clk  = ~in_clk;

    typedef struct packed {
        logic        first;
        logic [23:0] rgb;
    } exp_t;

    exp_t  q_exp[$];
    int    n_cmp = 0, n_bad = 0;
    int    cur_n = 2;
    bit    cur_scan = 0;
    int    cur_g = 128, cur_b = 0;
    string cur_tag = "R1 R2";
    bit    mon_en = 0;
    bit    done = 0;

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int ref_ch(int c, int g, int b, bit dim);
        int v;
        v = (c * g) / 128 + b;
        if (v < 0)   v = 0;
        if (v > 255) v = 255;
        if (dim)     v = v / 2;
        return v;
    endfunction

    function automatic logic [23:0] src_pix(int f, int y, int x);
        logic [7:0] r, g, b;
        r = 8'((x * 37 + y * 11 + f * 5) & 255);
        g = 8'((255 - x * 29 - y * 7 + f * 13) & 255);
        b = 8'((f * 53 + x * 71 + y * 3 + 90) & 255);
        return {r, g, b};
    endfunction

    function automatic logic [23:0] ref_pix(logic [23:0] p, bit dim);
        logic [23:0] o;
        for (int ch = 0; ch < 3; ch++)
            o[ch*8 +: 8] = 8'(ref_ch(int'(p[ch*8 +: 8]), cur_g, cur_b, dim));
        return o;
    endfunction

    task automatic send_line(int f, int y, bit first, int junk);
        exp_t e;
        for (int c = 0; c < cur_n; c++)
            for (int x = 0; x < W; x++)
                for (int r = 0; r < cur_n; r++) begin
                    e.first = first && (c == 0) && (x == 0) && (r == 0);
                    e.rgb   = ref_pix(src_pix(f, y, x), cur_scan && (c == cur_n - 1));
                    q_exp.push_back(e);
                end
        @(negedge in_clk);
        if (first) in_vsync = 1; else in_hsync = 1;
        in_valid = (junk > 0);
        in_rgb   = 24'hDEAD01;
        @(negedge in_clk);
        in_vsync = 0; in_hsync = 0; in_valid = 0;
        if (junk > 0) begin
            for (int j = 0; j < junk; j++) begin
                in_valid = 1; in_rgb = 24'hBAD000 + 24'(j);
                @(negedge in_clk);
            end
            in_valid = 1; in_hsync = 1; in_rgb = 24'hBADFFF;
            @(negedge in_clk);
            in_valid = 0; in_hsync = 0;
        end
        for (int x = 0; x < W; x++) begin
            in_valid = 1; in_rgb = src_pix(f, y, x);
            @(negedge in_clk);
        end
        in_valid = 0;
        repeat (GAP) @(negedge in_clk);
    endtask

    task automatic drain(string tag);
        repeat (120) @(negedge out_clk);
        check(q_exp.size() == 0, tag, q_exp.size(), 0);
    endtask

    // output monitor
    int run = 0, hs_run = 0;
    always @(negedge out_clk) begin
        if (out_rst_n && mon_en) begin
            if (out_de) begin
                if (q_exp.size() == 0) begin
                    check(0, {cur_tag, " R3 extra pixel"}, out_rgb, 0);
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    check(out_rgb == e.rgb, cur_tag, out_rgb, e.rgb);
                    check(out_vsync == e.first, "R5 vsync", out_vsync, e.first);
                end
                check(!out_hsync, "R6 hsync during de", out_hsync, 0);
                run++;
            end else begin
                if (run != 0) check(run == cur_n * W, "R1 R3 line length", run, cur_n * W);
                run = 0;
                check(!out_vsync, "R5 vsync off de", out_vsync, 0);
            end
            if (out_hsync) hs_run++;
            else begin
                if (hs_run != 0) check(hs_run == HSL, "R6 hsync width", hs_run, HSL);
                hs_run = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge out_clk);
        check(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (10) @(negedge out_clk);
        // R9: outputs quiet during reset
        check(out_de == 0 && out_hsync == 0 && out_vsync == 0, "R9 sync in reset",
              {out_de, out_hsync, out_vsync}, 0);
        check(out_rgb == 0, "R9 rgb in reset", out_rgb, 0);
        in_rst_n = 1; out_rst_n = 1;
        repeat (20) @(negedge out_clk);
        check(out_de == 0 && out_hsync == 0 && out_vsync == 0 && out_rgb == 0,
              "R9 idle after reset", {out_de, out_hsync, out_vsync, out_rgb}, 0);
        mon_en = 1;

        // vector table: each entry is one frame
        for (int i = 0; i < NVEC; i++) begin
            @(negedge out_clk);
            scale_code = VEC[i][18:17];
            scan_en    = VEC[i][16];
            contrast   = VEC[i][15:8];
            bright     = VEC[i][7:0];
            cur_n      = int'(VEC[i][21:19]);
            cur_scan   = VEC[i][16];
            cur_g      = int'(VEC[i][15:8]);
            cur_b      = int'($signed(VEC[i][7:0]));
            cur_tag    = cur_scan ? "R1 R2 R7 R8" : "R1 R2 R7";
            for (int y = 0; y < LINES; y++) send_line(i, y, y == 0, 0);
            drain("R2 R3 frame drained");
        end

        // R4: mid-frame scale change is deferred to the next frame
        @(negedge out_clk);
        scale_code = 2'd0; scan_en = 1; contrast = 8'h80; bright = 8'h00;
        cur_n = 2; cur_scan = 1; cur_g = 128; cur_b = 0; cur_tag = "R4 held factor";
        send_line(10, 0, 1, 0);
        @(negedge out_clk);
        scale_code = 2'd2;
        for (int y = 1; y < LINES; y++) send_line(10, y, 0, 0);
        drain("R4 frame drained");
        cur_n = 4; cur_tag = "R4 new factor";
        for (int y = 0; y < LINES; y++) send_line(11, y, y == 0, 0);
        drain("R4 R3 frame drained");

        // R10: truncated line with junk and a valid pixel on the marker cycle
        @(negedge out_clk);
        scale_code = 2'd1; scan_en = 0; contrast = 8'h80; bright = 8'h00;
        cur_n = 3; cur_scan = 0; cur_tag = "R10 column restart";
        send_line(12, 0, 1, 3);
        send_line(12, 1, 0, 5);
        send_line(12, 2, 0, 0);
        drain("R10 frame drained");

        report();
    end

endmodule